// File: doc/BRIEF.md
# Channel-Major Reordering Buffer

This block sits between a channelising filterbank and a bank of cross-multiply accumulators. The filterbank delivers one sample per channel for every time step, channel index running fastest. The buffer collects a block of `N_TIME` time steps by `N_CHAN` channels and plays it back with time running fastest. Each channel therefore arrives at the accumulators as one unbroken run of `N_TIME` samples, and the channels follow one another in ascending order. A flag on the last sample of every run tells the downstream accumulator to hand its sum off and clear.

Storage has two banks that swap roles. One block is written while the other is read. Each block carries its own replay count, so a stored block can be passed to the accumulators several times back to back. When the write bank is full and the read side has not yet finished every pass of the previous block, the input is held off with a valid/ready handshake.

Top module: `cturn_reorder`

## Requirements
- R1: A sample is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. The k-th accepted sample of a block (k counted from 0) belongs to time step k / N_CHAN and to channel k mod N_CHAN.
- R2: Each read pass of a block emits N_CHAN runs. Channels come in ascending order from 0. Within a run, the N_TIME samples of that channel come in ascending time order. `out_valid` stays high on every cycle of a pass.
- R3: `out_chan` carries the channel index of the sample on `out_data`. The first sample emitted after `out_valid` has been low belongs to channel 0.
- R4: `out_eoc` is high on the last sample of each run, the N_TIME-th, and low on every other valid sample.
- R5: `pass_count` is sampled together with the first accepted sample of a block. The block is then read max(`pass_count`, 1) times, so a value of 0 counts as one pass. Consecutive passes of a block follow each other with no idle cycle.
- R6: From the cycle after the last sample of a block is accepted, `in_ready` stays low until the read side has completed every pass of the earlier block. While `in_ready` is low, `in_valid` and `in_data` have no effect on the stored data.
- R7: While one block is being read out, samples of the next block are accepted.
- R8: When the read side is idle, `out_valid` first rises on the second clock edge after the edge that accepted the last sample of a block.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pass_count | input | PASS_W | Read passes for the block whose first sample is being accepted |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DATA_W | Input sample, channel-fastest order |
| in_ready | output | 1 | Buffer can accept a sample |
| out_valid | output | 1 | Output sample valid |
| out_data | output | DATA_W | Output sample, time-fastest order |
| out_chan | output | CH_W | Channel of the output sample |
| out_eoc | output | 1 | Last sample of a channel run |

## Verification
The bench sends several blocks in a row. One block has a single pass, one is replayed three times, one has a zero count with gaps in the input, and the last arrives while the input is stalled.

Each group of cases targets a specific kind of fault:
- A wrong read-address formula shows up as a time/channel swap in the tagged data values.
- A replay that ignores the count, or that fails to treat zero as one, changes the number of output samples.
- A swap taken too early either lets the stalled sample overwrite live data or makes `in_ready` rise while the older block is still being replayed.
- The latency and reset checks catch an extra or missing register stage.
- The run-flag checks catch an end-of-channel flag placed one sample off.

// File: rtl/cturn_pkg.sv
package cturn_pkg;
  // identifies one of the two storage banks
  typedef enum logic {BANK0 = 1'b0, BANK1 = 1'b1} bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK0) ? BANK1 : BANK0;
  endfunction
endpackage

// File: rtl/cturn_wr_seq.sv
// Sequential write address for the bank being filled
module cturn_wr_seq #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_first,
  output logic              wr_last
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (wr_fire) begin
      addr_d = (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign wr_addr  = addr_q;
  assign wr_first = (addr_q == '0);
  assign wr_last  = (addr_q == LAST_ADDR);
endmodule

// File: rtl/cturn_rd_agu.sv
// Transposed read address generator with replay passes
module cturn_rd_agu #(
  parameter int N_CHAN = 4,
  parameter int N_TIME = 8,
  parameter int PASS_W = 4,
  parameter int CH_W   = 2,
  parameter int TM_W   = 3,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PASS_W-1:0] npass,
  output logic              busy,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CH_W-1:0]   rd_chan,
  output logic              rd_eoc
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CHAN - 1);
  localparam logic [TM_W-1:0] LAST_TM = TM_W'(N_TIME - 1);

  logic              busy_q, busy_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [TM_W-1:0]   tm_q, tm_d;
  logic [PASS_W-1:0] left_q, left_d;

  always_comb begin
    busy_d = busy_q;
    ch_d   = ch_q;
    tm_d   = tm_q;
    left_d = left_q;
    if (start) begin
      busy_d = 1'b1;
      ch_d   = '0;
      tm_d   = '0;
      left_d = (npass == '0) ? '0 : npass - 1'b1;
    end else if (busy_q) begin
      if (tm_q == LAST_TM) begin
        tm_d = '0;
        if (ch_q == LAST_CH) begin
          ch_d = '0;
          if (left_q == '0) busy_d = 1'b0;
          else              left_d = left_q - 1'b1;
        end else begin
          ch_d = ch_q + 1'b1;
        end
      end else begin
        tm_d = tm_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ch_q   <= '0;
      tm_q   <= '0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      ch_q   <= ch_d;
      tm_q   <= tm_d;
      left_q <= left_d;
    end
  end

  assign busy    = busy_q;
  assign rd_addr = ADDR_W'(int'(tm_q) * N_CHAN + int'(ch_q));
  assign rd_chan = ch_q;
  assign rd_eoc  = (tm_q == LAST_TM);
endmodule

// File: rtl/cturn_bank_ram.sv
// Two-bank sample store, one write and one registered read per cycle
module cturn_bank_ram
  import cturn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  bank_e             wbank,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  bank_e             rbank,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 2 * DEPTH;
  localparam int IDX_W = $clog2(WORDS);

  logic [DATA_W-1:0] mem [WORDS];
  logic [IDX_W-1:0]  widx, ridx;
  logic [DATA_W-1:0] rdata_q;

  assign widx = IDX_W'(int'(wbank) * DEPTH + int'(waddr));
  assign ridx = IDX_W'(int'(rbank) * DEPTH + int'(raddr));

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[ridx];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cturn_reorder.sv
// Ping-pong corner-turn buffer: channel-fastest in, time-fastest out
module cturn_reorder
  import cturn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_CHAN = 4,
  parameter int N_TIME = 8,
  parameter int PASS_W = 4,
  localparam int CH_W  = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PASS_W-1:0] pass_count,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CH_W-1:0]   out_chan,
  output logic              out_eoc
);
  localparam int DEPTH  = N_CHAN * N_TIME;
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TM_W   = (N_TIME > 1) ? $clog2(N_TIME) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic              wr_fire, wr_first, wr_last;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              rd_busy, rd_eoc, swap;
  logic [CH_W-1:0]   rd_chan;

  bank_e             wr_bank_q, wr_bank_d, rd_bank_q, rd_bank_d;
  logic              wr_full_q, wr_full_d;
  logic [PASS_W-1:0] npass_q, npass_d;

  assign in_ready = !wr_full_q;
  assign wr_fire  = in_valid && in_ready;
  assign swap     = wr_full_q && !rd_busy;

  always_comb begin
    wr_bank_d = wr_bank_q;
    rd_bank_d = rd_bank_q;
    wr_full_d = wr_full_q;
    npass_d   = npass_q;
    if (wr_fire && wr_first) npass_d = pass_count;
    if (wr_fire && wr_last)  wr_full_d = 1'b1;
    if (swap) begin
      rd_bank_d = wr_bank_q;
      wr_bank_d = other_bank(wr_bank_q);
      wr_full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_bank_q <= BANK0;
      rd_bank_q <= BANK1;
      wr_full_q <= 1'b0;
      npass_q   <= '0;
    end else begin
      wr_bank_q <= wr_bank_d;
      rd_bank_q <= rd_bank_d;
      wr_full_q <= wr_full_d;
      npass_q   <= npass_d;
    end
  end

  cturn_wr_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) wr_seq_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .wr_first(wr_first), .wr_last(wr_last)
  );

  cturn_rd_agu #(
    .N_CHAN(N_CHAN), .N_TIME(N_TIME), .PASS_W(PASS_W),
    .CH_W(CH_W), .TM_W(TM_W), .ADDR_W(ADDR_W)
  ) rd_agu_i (
    .clk(clk), .rst_n(rst_sync_n), .start(swap), .npass(npass_q),
    .busy(rd_busy), .rd_addr(rd_addr), .rd_chan(rd_chan), .rd_eoc(rd_eoc)
  );

  cturn_bank_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) ram_i (
    .clk(clk), .we(wr_fire), .wbank(wr_bank_q), .waddr(wr_addr),
    .wdata(in_data), .re(rd_busy), .rbank(rd_bank_q), .raddr(rd_addr),
    .rdata(out_data)
  );

  // output tags aligned with the registered read
  logic            ov_q;
  logic [CH_W-1:0] oc_q;
  logic            oe_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ov_q <= 1'b0;
      oc_q <= '0;
      oe_q <= 1'b0;
    end else begin
      ov_q <= rd_busy;
      oc_q <= rd_chan;
      oe_q <= rd_busy && rd_eoc;
    end
  end

  assign out_valid = ov_q;
  assign out_chan  = oc_q;
  assign out_eoc   = oe_q;
endmodule

// File: rtl/cturn_reorder_chk.sv
module cturn_reorder_chk #(
  parameter int N_CHAN = 4,
  parameter int N_TIME = 8,
  parameter int CH_W   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            rd_busy,
  input logic            out_valid,
  input logic [CH_W-1:0] out_chan,
  input logic            out_eoc
);
  localparam int TM_W = (N_TIME > 1) ? $clog2(N_TIME) : 1;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CHAN - 1);
  localparam logic [TM_W-1:0] LAST_TM = TM_W'(N_TIME - 1);

  logic [TM_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (out_valid) run_q <= out_eoc ? '0 : run_q + 1'b1;
  end

  a_r4_eoc_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_eoc == (run_q == LAST_TM)));

  a_r2_run_holds_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eoc) |=> (out_valid && $stable(out_chan)));

  a_r2_chan_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eoc && out_chan != LAST_CH)
      |=> (out_valid && out_chan == CH_W'($past(out_chan) + 1'b1)));

  a_r3_burst_starts_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_chan == '0));

  a_r5_replay_gapless: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eoc && out_chan == LAST_CH && rd_busy)
      |=> (out_valid && out_chan == '0));

  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && rd_busy) |=> !in_ready);
endmodule

bind cturn_reorder cturn_reorder_chk #(
  .N_CHAN(N_CHAN), .N_TIME(N_TIME), .CH_W(CH_W)
) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .in_ready(in_ready), .rd_busy(rd_busy),
  .out_valid(out_valid), .out_chan(out_chan), .out_eoc(out_eoc)
);

// File: tb/cturn_reorder_tb_top.sv
module cturn_reorder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NT = 8;
  localparam int WD_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  pass_count;
  logic        in_valid;
  logic [15:0] in_data;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;
  logic [1:0]  out_chan;
  logic        out_eoc;

  int n_checks = 0;
  int n_fails  = 0;
  int n_out    = 0;
  bit done     = 1'b0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cturn_reorder #(.DATA_W(16), .N_CHAN(NC), .N_TIME(NT), .PASS_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .pass_count(pass_count),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data),
    .out_chan(out_chan), .out_eoc(out_eoc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  // sample tag: block in bits 11:8, time in 7:4, channel in 3:0
  function automatic int tag(input int blk, input int t, input int c);
    return blk * 256 + t * 16 + c;
  endfunction

  // reference model: expected output stream per R1, R2, R4, R5
  task automatic expect_block(input int blk, input int npass);
    int passes;
    passes = (npass == 0) ? 1 : npass;
    for (int p = 0; p < passes; p++)
      for (int c = 0; c < NC; c++)
        for (int t = 0; t < NT; t++)
          exp_q.push_back(((t == NT-1) ? (1 << 24) : 0) | (c << 16) | tag(blk, t, c));
  endtask

  // one sample, held until accepted (R1, R6)
  task automatic push_one(input logic [15:0] d);
    logic acc;
    acc = 1'b0;
    in_valid = 1'b1;
    in_data  = d;
    while (!acc) begin
      acc = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic send_block(input int blk, input int npass, input bit gaps);
    expect_block(blk, npass);
    pass_count = 4'(npass);
    for (int t = 0; t < NT; t++)
      for (int c = 0; c < NC; c++) begin
        push_one(16'(tag(blk, t, c)));
        if (t == 0 && c == 0) pass_count = 4'd9; // no effect after first sample (R5)
        if (gaps) @(negedge clk);
      end
  endtask

  // monitor compares every output cycle with the model (R2, R3, R4)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_out++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected output", int'(out_data), 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(out_data == 16'(e), "R2 data order", int'(out_data), e & 16'hffff);
        check(out_chan == 2'((e >> 16) & 3), "R3 channel tag", int'(out_chan), (e >> 16) & 3);
        check(out_eoc == ((e >> 24) & 1), "R4 end of run", int'(out_eoc), (e >> 24) & 1);
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    pass_count = 4'd1;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);

    // block 1: single pass, read side idle
    send_block(1, 1, 1'b0);
    check(out_valid == 1'b0, "R8 latency edge 1", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 latency edge 1b", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R8 latency edge 2", int'(out_valid), 1);

    // block 2: three passes, written while block 1 is read
    expect_block(2, 3);
    pass_count = 4'd3;
    push_one(16'(tag(2, 0, 0)));
    pass_count = 4'd1;
    check(out_valid == 1'b1, "R7 accept during read", int'(out_valid), 1);
    for (int k = 1; k < NC*NT; k++) push_one(16'(tag(2, k / NC, k % NC)));

    // block 3: pass count 0, gaps in input
    send_block(3, 0, 1'b1);
    check(in_ready == 1'b0, "R6 stall while replaying", int'(in_ready), 0);
    check(out_valid == 1'b1, "R6 older block still reading", int'(out_valid), 1);

    // block 4: two passes, first sample offered during the stall
    send_block(4, 2, 1'b0);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(n_out == NC*NT*(1 + 3 + 1 + 2), "R5 total samples", n_out, NC*NT*7);
    check(out_valid == 1'b0, "R2 idle after last block", int'(out_valid), 0);
    check(in_ready == 1'b1, "R6 ready when idle", int'(in_ready), 1);
    finish_run();
  end
endmodule